// File: doc/BRIEF.md
# Input edge pulse and stabilizer

This block conditions a single asynchronous input, such as a push button or a status line from another board, so that one clock domain can use it safely. The raw input is sampled on every rising clock edge into a short shift chain of three flops. All later logic reads only this chain and never the raw pin.

Two results are derived from the shared chain. The first is a one-shot pulse for logic that reacts to events: the block sees two consecutive high samples that follow a low sample and raises a pulse for exactly one clock. The second is a filtered level for logic that reacts to states: this level follows the input only when all three stored samples agree, and holds its value otherwise.

Both results come straight out of flops, so the outputs never carry decode glitches. The level filter is a two-state machine:
- `LVL_LOW` moves to `LVL_HIGH` on the transition RISE, which fires when all samples are high.
- `LVL_HIGH` moves to `LVL_LOW` on the transition FALL, which fires when all samples are low.
- In either state, disagreeing samples leave the state as it is (transition HOLD).

Top module: `pin_conditioner`

## Requirements
- R1: An active-low asynchronous reset drives `edge_pulse` and `stable_level` to 0 at once, without waiting for a clock edge. It also clears the sample history, so if the input is high when reset is released, a pulse still follows as for a fresh low-to-high change.
- R2: The pulse fires after two consecutive high samples that follow a low sample. Counting the first edge that samples the input high as edge 1, `edge_pulse` is 1 in the cycle after edge 3.
- R3: `edge_pulse` is never 1 for two consecutive cycles. It returns to 0 after one cycle even if the input stays high.
- R4: When a single high sample has low samples on both sides, `edge_pulse` stays 0 and `stable_level` stays 0.
- R5: `stable_level` becomes 1 in the cycle after edge 4 once three consecutive high samples have been taken (edges 1 to 3). It becomes 0 under the same timing once three consecutive low samples have been taken.
- R6: `stable_level` keeps its value whenever the three newest samples disagree. A glitch of either polarity that lasts one cycle never changes it.
- R7: A one-sample low dip while `stable_level` is 1 re-arms the pulse. Counting the edge that samples the dip as edge 0, a pulse appears in the cycle after edge 3 while the level stays 1. A two-sample high burst that starts from low gives a pulse while the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_in | input | 1 | Unsynchronized external input |
| edge_pulse | output | 1 | One-cycle pulse for each qualified rising transition |
| stable_level | output | 1 | Filtered level; changes only when three samples agree |

## Verification
The one-shot and the level filter read the same three samples in the same cycle, so they can act together. The interesting case is a one-sample low dip while the filtered level is high. The one-shot qualifies a new rising edge in the same cycle in which the level filter must decide to hold rather than fall. The bench provokes this by first settling the input high and then dropping it for exactly one sample. It then checks, cycle by cycle, that a single pulse appears three edges after the dip while `stable_level` stays 1 throughout. The mirror case, a two-sample high burst that starts from low, checks that a pulse appears while the level stays 0.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;

    // States of the level filter; the encoding equals the level it drives
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/pc_sample_chain.sv
module pc_sample_chain #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);

    // taps[0] holds the newest sample, taps[DEPTH-1] the oldest
    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], din};
        end
    end

    assign taps = chain_q;

endmodule

// File: rtl/pc_edge_oneshot.sv
module pc_edge_oneshot #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] taps,
    output logic             pulse
);

    localparam int NEWER = DEPTH - 1;

    // all newer samples high, oldest sample still low
    logic fire;
    logic pulse_q;

    always_comb begin
        fire = (&taps[NEWER-1:0]) & ~taps[NEWER];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/pc_level_filter.sv
module pc_level_filter
    import pin_cond_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] taps,
    output logic             level
);

    lvl_state_e state_q;
    lvl_state_e state_d;
    logic       all_hi;
    logic       all_lo;

    always_comb begin
        all_hi = &taps;
        all_lo = ~|taps;
    end

    // next-state: RISE, FALL, otherwise HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (all_hi) state_d = LVL_HIGH;
            LVL_HIGH: if (all_lo) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode from the state flop only
    always_comb begin
        unique case (state_q)
            LVL_HIGH: level = 1'b1;
            default:  level = 1'b0;
        endcase
    end

endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic edge_pulse,
    output logic stable_level
);

    logic [SAMPLES-1:0] taps;

    pc_sample_chain #(.DEPTH(SAMPLES)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .taps  (taps)
    );

    pc_edge_oneshot #(.DEPTH(SAMPLES)) u_oneshot (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .pulse (edge_pulse)
    );

    pc_level_filter #(.DEPTH(SAMPLES)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .level (stable_level)
    );

endmodule

// File: rtl/pin_conditioner_chk.sv
module pin_conditioner_chk #(
    parameter int SAMPLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic raw_in,
    input logic edge_pulse,
    input logic stable_level
);

    // edges since reset release, saturating; gates history-based checks
    logic [2:0] since_rst;
    logic       warmed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    assign warmed = (since_rst == 3'd7);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!edge_pulse && !stable_level); // R1
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse); // R3

    if (SAMPLES == 3) begin : g_three
        AST_PULSE_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
            (warmed && edge_pulse) |->
            ($past(raw_in, 2) && $past(raw_in, 3) && !$past(raw_in, 4))); // R2

        AST_PULSE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
            (warmed && $past(raw_in, 2) && $past(raw_in, 3) && !$past(raw_in, 4))
            |-> edge_pulse); // R2

        AST_LEVEL_RISE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            (warmed && $rose(stable_level)) |->
            ($past(raw_in, 2) && $past(raw_in, 3) && $past(raw_in, 4))); // R5

        AST_LEVEL_FALL_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            (warmed && $fell(stable_level)) |->
            (!$past(raw_in, 2) && !$past(raw_in, 3) && !$past(raw_in, 4))); // R5

        AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (warmed && (($past(raw_in, 2) != $past(raw_in, 3)) ||
                        ($past(raw_in, 3) != $past(raw_in, 4))))
            |-> $stable(stable_level)); // R6
    end

endmodule

bind pin_conditioner pin_conditioner_chk #(.SAMPLES(SAMPLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .raw_in       (raw_in),
    .edge_pulse   (edge_pulse),
    .stable_level (stable_level)
);

// File: tb/pin_conditioner_tb.sv
`timescale 1ns/1ps
module pin_conditioner_tb;

    logic clk;
    logic rst_n;
    logic raw_in;
    logic edge_pulse;
    logic stable_level;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    pin_conditioner u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_in       (raw_in),
        .edge_pulse   (edge_pulse),
        .stable_level (stable_level)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic expect_now(input logic ep, input logic el, input string req);
        n_cmp++;
        if (edge_pulse !== ep || stable_level !== el) begin
            n_bad++;
            $display("FAIL %s: pulse=%b level=%b expected pulse=%b level=%b",
                     req, edge_pulse, stable_level, ep, el);
        end
    endtask

    // drive one sample, let one edge take it, check outputs after that edge
    task automatic step(input logic v, input logic ep, input logic el, input string req);
        raw_in = v;
        @(posedge clk);
        #1;
        expect_now(ep, el, req);
    endtask

    task automatic settle(input logic v);
        for (int i = 0; i < 6; i++) begin
            raw_in = v;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset;
        rst_n  = 1'b0;
        raw_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        expect_now(1'b0, 1'b0, "R1 held in reset");
        rst_n = 1'b1;               // released between edges, input high
        step(1'b1, 1'b0, 1'b0, "R1 edge1");
        step(1'b1, 1'b0, 1'b0, "R1 edge2");
        step(1'b1, 1'b1, 1'b0, "R1 cleared history gives pulse");
        step(1'b1, 1'b0, 1'b1, "R1 level after release");
        rst_n = 1'b0;               // asynchronous assertion mid-cycle
        #1;
        expect_now(1'b0, 1'b0, "R1 async clear");
        @(posedge clk);
        #1;
        raw_in = 1'b0;
        rst_n  = 1'b1;
        settle(1'b0);
        expect_now(1'b0, 1'b0, "R1 idle after reset");
    endtask

    task automatic t_rise;
        settle(1'b0);
        step(1'b1, 1'b0, 1'b0, "R2 edge1");
        step(1'b1, 1'b0, 1'b0, "R2 edge2");
        step(1'b1, 1'b1, 1'b0, "R2 pulse after edge3");
        step(1'b1, 1'b0, 1'b1, "R5 level rises after edge4");
        step(1'b1, 1'b0, 1'b1, "R3 no repeat pulse");
        step(1'b1, 1'b0, 1'b1, "R3 still single");
    endtask

    task automatic t_fall;
        settle(1'b1);
        step(1'b0, 1'b0, 1'b1, "R6 one low sample");
        step(1'b0, 1'b0, 1'b1, "R6 two low samples");
        step(1'b0, 1'b0, 1'b1, "R5 not yet falling");
        step(1'b0, 1'b0, 1'b0, "R5 level falls after edge4");
        step(1'b0, 1'b0, 1'b0, "R5 stays low");
    endtask

    task automatic t_short_high;
        settle(1'b0);
        step(1'b1, 1'b0, 1'b0, "R4 single high sample");
        step(1'b0, 1'b0, 1'b0, "R4 no pulse");
        step(1'b0, 1'b0, 1'b0, "R4 no late pulse");
        step(1'b0, 1'b0, 1'b0, "R6 level unchanged by high glitch");
        step(1'b0, 1'b0, 1'b0, "R4 quiet");
    endtask

    task automatic t_burst2;
        settle(1'b0);
        step(1'b1, 1'b0, 1'b0, "R7 burst edge1");
        step(1'b1, 1'b0, 1'b0, "R7 burst edge2");
        step(1'b0, 1'b1, 1'b0, "R7 burst pulse, level low");
        step(1'b0, 1'b0, 1'b0, "R3 burst pulse single");
        step(1'b0, 1'b0, 1'b0, "R6 burst level held low");
        step(1'b0, 1'b0, 1'b0, "R6 burst level still low");
    endtask

    task automatic t_dip;
        settle(1'b1);
        expect_now(1'b0, 1'b1, "R7 settled high");
        step(1'b0, 1'b0, 1'b1, "R6 dip sampled");
        step(1'b1, 1'b0, 1'b1, "R7 dip edge1");
        step(1'b1, 1'b0, 1'b1, "R7 dip edge2");
        step(1'b1, 1'b1, 1'b1, "R7 re-armed pulse, level high");
        step(1'b1, 1'b0, 1'b1, "R3 dip pulse single");
        step(1'b1, 1'b0, 1'b1, "R6 level unchanged by low glitch");
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        raw_in = 1'b0;
        t_reset();
        t_rise();
        t_fall();
        t_short_high();
        t_burst2();
        t_dip();
        finished = 1;
        report();
        $finish;
    end

endmodule